// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one complete I2C master read or write transfer on top of a separate bit-level engine. The engine owns line timing and line control. The sequencer only decides which bus operation comes next: START, STOP, write one bit, read one bit, or abort. It hands each operation to the engine and waits for the engine to report completion.

A transfer is requested with a one-cycle `start` pulse. The pulse carries a 7-bit or 10-bit target address, a direction, a byte count, and two flags. One flag skips the START condition and the address phase. The other leaves the bus held at the end instead of issuing STOP. These two flags let a caller chain several transfers into one bus transaction.

Bytes to be written arrive on a byte-wide valid/ready input stream, and received bytes leave on a byte-wide valid/ready output stream. Every byte goes on the bus most significant bit first and is followed by an acknowledge bit. When the transfer ends, `done` pulses for one cycle and `result` carries a code that tells each failure apart. After any failure the sequencer first asks the engine to abort, which releases the lines and recovers the bus, and only then reports.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A 7-bit address is sent as one byte, {addr[6:0], dir}, with dir = 1 for read and 0 for write.
- R2: When `req_ten_bit` is set, the address is sent as two bytes: first {5'b11110, addr[9:8], dir}, then addr[7:0].
- R3: When `req_no_start` is set, no START operation and no address byte is issued, and the first operation belongs to the first data byte.
- R4: A transfer that completes without error issues a STOP operation (op code 1) as its last operation, unless `req_no_stop` is set, in which case no STOP is issued.
- R5: Each written byte is issued as 8 write-bit operations (op code 2), most significant bit first, carried on `be_wbit`. One read-bit operation (op code 3) follows. A returned `be_rbit` of 0 is an acknowledge and 1 is a NACK.
- R6: A NACK on any address byte issues an abort operation (op code 4) and ends the transfer with result 2 (no device).
- R7: A NACK on a written data byte issues an abort operation and ends the transfer with result 3 (I/O error).
- R8: In a read, each byte is assembled from 8 read-bit operations, most significant bit first. A write-bit operation follows, with `be_wbit` = 0 (acknowledge) for every byte except the last, which gets 1 (NACK).
- R9: A start request with `req_len` = 0 makes no engine request, and `done` rises in the cycle after the request with result 1 (invalid argument).
- R10: If the engine reports `be_arb_lost` on completing any operation other than an abort, an abort operation follows and the result is 4 (try again). This takes priority over a simultaneous timeout.
- R11: If the engine reports `be_timeout`, and not `be_arb_lost`, on completing any operation other than an abort, an abort operation follows and the result is 5 (timeout).
- R12: No bit of a written data byte is issued before that byte is accepted on the input stream, and `tx_ready` is never high while an engine request is open. A received byte appears on `rx_valid` only after its acknowledge bit has completed, and it is held stable until `rx_ready`.
- R13: `be_req` stays high with `be_op` and `be_wbit` unchanged until `be_done`. `busy` is high from the accepted request through the one-cycle `done` pulse. `result` is 0 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request pulse, accepted when not busy |
| req_addr | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| req_ten_bit | input | 1 | Select 10-bit address encoding |
| req_read | input | 1 | 1 = read transfer, 0 = write transfer |
| req_len | input | LEN_W | Number of data bytes |
| req_no_start | input | 1 | Skip START and address phase |
| req_no_stop | input | 1 | Omit the final STOP |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 invalid, 2 no device, 3 I/O, 4 try again, 5 timeout |
| tx_data | input | 8 | Byte to write |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Write byte taken this cycle if valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Received byte taken |
| be_req | output | 1 | Bus operation requested |
| be_op | output | 3 | 0 START, 1 STOP, 2 write bit, 3 read bit, 4 abort |
| be_wbit | output | 1 | Bit value for a write-bit operation |
| be_done | input | 1 | Engine finished the requested operation |
| be_rbit | input | 1 | Sampled line value for a read-bit operation |
| be_arb_lost | input | 1 | Arbitration lost during the operation |
| be_timeout | input | 1 | Clock-stretch timeout during the operation |

## Verification
The assertions check the cycle-level contracts on every cycle. They cover the operation handshake holding steady until completion, a received byte appearing only after an acknowledge bit has been written, that byte staying still while back-pressured, the transmit stream being idle whenever a bus request is open, the zero-length rejection, and an abort always following an arbitration loss. Only the bench's scenarios can show the full content of a transfer. That content is the exact operation stream with address encodings and bit order, the acknowledge pattern of reads, which error code each NACK position or injected engine fault produces, and which operations are skipped under the no-START and no-STOP flags.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   localparam int BYTE_W = 8;
   localparam int ADDR_W = 10;

   typedef enum logic [2:0] {
      OP_START = 3'd0,
      OP_STOP  = 3'd1,
      OP_WBIT  = 3'd2,
      OP_RBIT  = 3'd3,
      OP_ABORT = 3'd4
   } bus_op_e;

   typedef enum logic [2:0] {
      RES_OK      = 3'd0,
      RES_INVAL   = 3'd1,
      RES_NODEV   = 3'd2,
      RES_IO      = 3'd3,
      RES_AGAIN   = 3'd4,
      RES_TIMEOUT = 3'd5
   } xfer_res_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_START,
      S_ABIT,
      S_AACK,
      S_TX_WAIT,
      S_TBIT,
      S_TACK,
      S_RBIT,
      S_RACK,
      S_RPUSH,
      S_STOP,
      S_ABORT,
      S_DONE
   } seq_state_e;

endpackage

// File: rtl/i2c_addr_fmt.sv
module i2c_addr_fmt
   import i2c_seq_pkg::*;
#(
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ten_bit,
   input  logic              rd,
   output logic [BYTE_W-1:0] byte0,
   output logic [BYTE_W-1:0] byte1,
   output logic              two
);

   generate
      if (TEN_BIT_EN) begin : g_ten
         // leading pattern marks a two-byte address
         localparam logic [4:0] TEN_HDR = 5'b11110;
         assign two   = ten_bit;
         assign byte0 = ten_bit ? {TEN_HDR, addr[9:8], rd} : {addr[6:0], rd};
         assign byte1 = addr[7:0];
      end else begin : g_seven
         logic spare_bits;
         assign spare_bits = ^{ten_bit, addr[9:7]};
         assign two   = 1'b0;
         assign byte0 = {addr[6:0], rd};
         assign byte1 = {BYTE_W{spare_bits}} & '0;
      end
   endgenerate

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         in_bit,
   output logic         msb,
   output logic         last,
   output logic [W-1:0] value
);

   localparam int CW = (W > 2) ? $clog2(W) : 1;

   initial begin
      assert (W >= 2) else $error("i2c_byte_shift: W must be at least 2");
   end

   logic [W-1:0]  sr_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sr_q  <= load_val;
         cnt_q <= '0;
      end else if (shift) begin
         sr_q  <= {sr_q[W-2:0], in_bit};
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign msb   = sr_q[W-1];
   assign last  = (cnt_q == CW'(W-1));
   assign value = sr_q;

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
   import i2c_seq_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_ten_bit,
   input  logic              req_read,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_no_start,
   input  logic              req_no_stop,
   output logic              busy,
   output logic              done,
   output logic [2:0]        result,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_ten_bit,
   output logic              cur_read,
   input  logic [BYTE_W-1:0] addr_b0,
   input  logic [BYTE_W-1:0] addr_b1,
   input  logic              addr_two,
   output logic              sh_load,
   output logic [BYTE_W-1:0] sh_val,
   output logic              sh_shift,
   output logic              sh_in,
   input  logic              sh_msb,
   input  logic              sh_last,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              rx_valid,
   input  logic              rx_ready,
   input  logic [BYTE_W-1:0] rx_data,
   output logic              be_req,
   output logic [2:0]        be_op,
   output logic              be_wbit,
   input  logic              be_done,
   input  logic              be_rbit,
   input  logic              be_arb_lost,
   input  logic              be_timeout
);

   seq_state_e state_q, state_d;
   xfer_res_e  res_q, res_d;
   bus_op_e    op_w;
   logic [LEN_W-1:0]  left_q, left_d;
   logic              abyte_q, abyte_d;
   logic [ADDR_W-1:0] addr_q;
   logic              ten_q, rd_q, nostop_q;
   logic              op_ok, op_err, last_byte;
   seq_state_e        data_entry, tail_state;

   // ---------------- request capture ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         ten_q    <= 1'b0;
         rd_q     <= 1'b0;
         nostop_q <= 1'b0;
      end else if (start && (state_q == S_IDLE)) begin
         addr_q   <= req_addr;
         ten_q    <= req_ten_bit;
         rd_q     <= req_read;
         nostop_q <= req_no_stop;
      end
   end

   assign cur_addr    = addr_q;
   assign cur_ten_bit = ten_q;
   assign cur_read    = rd_q;

   // ---------------- bus operation request ----------------
   assign last_byte = (left_q == LEN_W'(1));

   always_comb begin
      be_req  = 1'b1;
      op_w    = OP_WBIT;
      be_wbit = 1'b1;
      unique case (state_q)
         S_START: op_w = OP_START;
         S_ABIT,
         S_TBIT:  be_wbit = sh_msb;
         S_AACK,
         S_TACK,
         S_RBIT:  op_w = OP_RBIT;
         S_RACK:  be_wbit = last_byte;
         S_STOP:  op_w = OP_STOP;
         S_ABORT: op_w = OP_ABORT;
         default: be_req = 1'b0;
      endcase
   end

   assign be_op = op_w;

   assign op_ok  = be_req && be_done && !be_arb_lost && !be_timeout;
   assign op_err = be_req && be_done && (be_arb_lost || be_timeout) &&
                   (state_q != S_ABORT);

   assign data_entry = rd_q ? S_RBIT : S_TX_WAIT;
   assign tail_state = nostop_q ? S_DONE : S_STOP;

   // ---------------- sequencing ----------------
   always_comb begin
      state_d  = state_q;
      res_d    = res_q;
      left_d   = left_q;
      abyte_d  = abyte_q;
      sh_load  = 1'b0;
      sh_val   = '0;
      sh_shift = 1'b0;
      sh_in    = be_rbit;
      unique case (state_q)
         S_IDLE: begin
            if (start) begin
               left_d  = req_len;
               res_d   = RES_OK;
               abyte_d = 1'b0;
               sh_load = 1'b1;
               if (req_len == '0) begin
                  res_d   = RES_INVAL;
                  state_d = S_DONE;
               end else if (req_no_start) begin
                  state_d = req_read ? S_RBIT : S_TX_WAIT;
               end else begin
                  state_d = S_START;
               end
            end
         end
         S_START: begin
            if (op_ok) begin
               sh_load = 1'b1;
               sh_val  = addr_b0;
               abyte_d = 1'b0;
               state_d = S_ABIT;
            end
         end
         S_ABIT: begin
            if (op_ok) begin
               sh_shift = 1'b1;
               if (sh_last) state_d = S_AACK;
            end
         end
         S_AACK: begin
            if (op_ok) begin
               if (be_rbit) begin
                  res_d   = RES_NODEV;
                  state_d = S_ABORT;
               end else if (!abyte_q && addr_two) begin
                  abyte_d = 1'b1;
                  sh_load = 1'b1;
                  sh_val  = addr_b1;
                  state_d = S_ABIT;
               end else begin
                  sh_load = 1'b1;
                  state_d = data_entry;
               end
            end
         end
         S_TX_WAIT: begin
            if (tx_valid) begin
               sh_load = 1'b1;
               sh_val  = tx_data;
               state_d = S_TBIT;
            end
         end
         S_TBIT: begin
            if (op_ok) begin
               sh_shift = 1'b1;
               if (sh_last) state_d = S_TACK;
            end
         end
         S_TACK: begin
            if (op_ok) begin
               if (be_rbit) begin
                  res_d   = RES_IO;
                  state_d = S_ABORT;
               end else begin
                  left_d  = left_q - 1'b1;
                  state_d = last_byte ? tail_state : S_TX_WAIT;
               end
            end
         end
         S_RBIT: begin
            if (op_ok) begin
               sh_shift = 1'b1;
               if (sh_last) state_d = S_RACK;
            end
         end
         S_RACK: begin
            if (op_ok) state_d = S_RPUSH;
         end
         S_RPUSH: begin
            if (rx_ready) begin
               left_d = left_q - 1'b1;
               if (last_byte) begin
                  state_d = tail_state;
               end else begin
                  sh_load = 1'b1;
                  state_d = S_RBIT;
               end
            end
         end
         S_STOP: begin
            if (op_ok) state_d = S_DONE;
         end
         S_ABORT: begin
            if (be_done) state_d = S_DONE;
         end
         S_DONE: state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase

      if (op_err) begin
         state_d  = S_ABORT;
         res_d    = be_arb_lost ? RES_AGAIN : RES_TIMEOUT;
         left_d   = left_q;
         abyte_d  = abyte_q;
         sh_load  = 1'b0;
         sh_shift = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         res_q   <= RES_OK;
         left_q  <= '0;
         abyte_q <= 1'b0;
      end else begin
         state_q <= state_d;
         res_q   <= res_d;
         left_q  <= left_d;
         abyte_q <= abyte_d;
      end
   end

   assign busy     = (state_q != S_IDLE);
   assign done     = (state_q == S_DONE);
   assign result   = res_q;
   assign tx_ready = (state_q == S_TX_WAIT);
   assign rx_valid = (state_q == S_RPUSH);

   // ---------------- assertions ----------------
   // R13
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      be_req && !be_done |=> be_req && $stable(be_op) && $stable(be_wbit));

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   rx_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(be_done && (be_op == OP_WBIT)));

   // R12
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

   // R12
   tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> !be_req);

   // R9
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && (req_len == '0) |=> done && (result == 3'd1) && !be_req);

   // R10
   arb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      be_req && be_done && be_arb_lost && (be_op != OP_ABORT)
      |=> be_req && (be_op == OP_ABORT));

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
   import i2c_seq_pkg::*;
#(
   parameter int LEN_W      = 8,
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [9:0]        req_addr,
   input  logic              req_ten_bit,
   input  logic              req_read,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_no_start,
   input  logic              req_no_stop,
   output logic              busy,
   output logic              done,
   output logic [2:0]        result,
   input  logic [7:0]        tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [7:0]        rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic              be_req,
   output logic [2:0]        be_op,
   output logic              be_wbit,
   input  logic              be_done,
   input  logic              be_rbit,
   input  logic              be_arb_lost,
   input  logic              be_timeout
);

   initial begin
      assert (LEN_W >= 1 && LEN_W <= 16) else $error("i2c_xfer_seq: LEN_W out of range");
      assert (BYTE_W == 8) else $error("i2c_xfer_seq: byte width must be 8");
   end

   logic [ADDR_W-1:0] cur_addr;
   logic              cur_ten_bit, cur_read;
   logic [BYTE_W-1:0] addr_b0, addr_b1;
   logic              addr_two;
   logic              sh_load, sh_shift, sh_in, sh_msb, sh_last;
   logic [BYTE_W-1:0] sh_val, sh_value;

   i2c_addr_fmt #(
      .TEN_BIT_EN (TEN_BIT_EN)
   ) u_addr_fmt (
      .addr    (cur_addr),
      .ten_bit (cur_ten_bit),
      .rd      (cur_read),
      .byte0   (addr_b0),
      .byte1   (addr_b1),
      .two     (addr_two)
   );

   i2c_byte_shift #(
      .W (BYTE_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .shift    (sh_shift),
      .in_bit   (sh_in),
      .msb      (sh_msb),
      .last     (sh_last),
      .value    (sh_value)
   );

   assign rx_data = sh_value;

   i2c_xfer_fsm #(
      .LEN_W (LEN_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .req_addr     (req_addr),
      .req_ten_bit  (req_ten_bit),
      .req_read     (req_read),
      .req_len      (req_len),
      .req_no_start (req_no_start),
      .req_no_stop  (req_no_stop),
      .busy         (busy),
      .done         (done),
      .result       (result),
      .cur_addr     (cur_addr),
      .cur_ten_bit  (cur_ten_bit),
      .cur_read     (cur_read),
      .addr_b0      (addr_b0),
      .addr_b1      (addr_b1),
      .addr_two     (addr_two),
      .sh_load      (sh_load),
      .sh_val       (sh_val),
      .sh_shift     (sh_shift),
      .sh_in        (sh_in),
      .sh_msb       (sh_msb),
      .sh_last      (sh_last),
      .tx_data      (tx_data),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .rx_valid     (rx_valid),
      .rx_ready     (rx_ready),
      .rx_data      (sh_value),
      .be_req       (be_req),
      .be_op        (be_op),
      .be_wbit      (be_wbit),
      .be_done      (be_done),
      .be_rbit      (be_rbit),
      .be_arb_lost  (be_arb_lost),
      .be_timeout   (be_timeout)
   );

endmodule

// File: tb/i2c_xfer_seq_bench.sv
module i2c_xfer_seq_bench;

   localparam int LEN_W = 8;
   localparam int LOGN  = 512;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic       start;
   logic [9:0] req_addr;
   logic       req_ten_bit, req_read, req_no_start, req_no_stop;
   logic [LEN_W-1:0] req_len;
   logic       busy, done;
   logic [2:0] result;
   logic [7:0] tx_data;
   logic       tx_valid, tx_ready;
   logic [7:0] rx_data;
   logic       rx_valid, rx_ready;
   logic       be_req, be_wbit, be_done, be_rbit, be_arb_lost, be_timeout;
   logic [2:0] be_op;

   i2c_xfer_seq #(.LEN_W(LEN_W)) u_i2c_xfer_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
      .req_ten_bit(req_ten_bit), .req_read(req_read), .req_len(req_len),
      .req_no_start(req_no_start), .req_no_stop(req_no_stop),
      .busy(busy), .done(done), .result(result),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .be_req(be_req), .be_op(be_op), .be_wbit(be_wbit), .be_done(be_done),
      .be_rbit(be_rbit), .be_arb_lost(be_arb_lost), .be_timeout(be_timeout)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   // engine model state
   int         log_n;
   logic [2:0] log_op  [LOGN];
   logic       log_bit [LOGN];
   logic       resp    [LOGN];
   int         arb_at, to_at;

   // expected stream
   int         ne;
   logic [2:0] eop  [LOGN];
   logic       ebit [LOGN];
   logic       g_halt;
   logic [2:0] g_res;
   int         g_wb, g_nack;
   logic [7:0] exp_rx [32];
   int         exp_rx_n;

   // streams
   logic [7:0] tx_buf [32];
   int         tx_n, tx_idx, tx_gap;
   logic       tx_taken, tx_en;
   logic [7:0] rx_got [32];
   int         rx_n;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // global watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R13 watchdog expired: actual %0d expected %0d", cyc, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // bit-engine model: answers each request one cycle after it is seen
   always @(negedge clk) begin
      if (!rst_n) begin
         be_done = 1'b0; be_rbit = 1'b0; be_arb_lost = 1'b0; be_timeout = 1'b0;
      end else if (be_done) begin
         be_done = 1'b0; be_arb_lost = 1'b0; be_timeout = 1'b0;
      end else if (be_req && log_n < LOGN) begin
         log_op[log_n]  = be_op;
         log_bit[log_n] = be_wbit;
         be_rbit        = resp[log_n];
         be_arb_lost    = (log_n == arb_at);
         be_timeout     = (log_n == to_at);
         log_n++;
         be_done = 1'b1;
      end
   end

   // transmit stream source with gaps
   always @(negedge clk) begin
      if (tx_taken) begin
         tx_taken = 1'b0;
         tx_valid = 1'b0;
         tx_idx++;
         tx_gap = tx_idx % 3;
      end else if (!tx_valid) begin
         if (tx_gap > 0) tx_gap--;
         else if (tx_en && tx_idx < tx_n) begin
            tx_valid = 1'b1;
            tx_data  = tx_buf[tx_idx];
         end
      end
      if (tx_valid && tx_ready) tx_taken = 1'b1;
   end

   // receive stream sink with back-pressure
   always @(negedge clk) begin
      rx_ready = ((cyc % 3) != 0);
      if (rx_valid && rx_ready && rx_n < 32) begin
         rx_got[rx_n] = rx_data;
         rx_n++;
      end
   end

   task automatic emit(input logic [2:0] op, input logic b, input logic rb);
      eop[ne]  = op;
      ebit[ne] = b;
      resp[ne] = rb;
      if (ne == arb_at) begin
         g_halt = 1'b1; g_res = 3'd4;
      end else if (ne == to_at) begin
         g_halt = 1'b1; g_res = 3'd5;
      end
      ne++;
   endtask

   task automatic send_wbyte(input logic [7:0] b, input logic [2:0] code);
      for (int i = 7; i >= 0; i--) if (!g_halt) emit(3'd2, b[i], 1'b0);
      if (!g_halt) begin
         logic nk;
         nk = (g_wb == g_nack);
         emit(3'd3, 1'b0, nk);
         if (!g_halt && nk) begin
            g_halt = 1'b1; g_res = code;
         end
      end
      g_wb++;
   endtask

   task automatic run(input string tag, input logic [9:0] addr, input logic ten,
                      input logic rd, input logic nos, input logic nop, input int len,
                      input int nack_at, input int a_at, input int t_at);
      int exp_tx;
      int wait_n;
      int bad_at;
      // ---- expected stream from the requirements ----
      for (int i = 0; i < LOGN; i++) resp[i] = 1'b0;
      ne = 0; g_halt = 1'b0; g_res = 3'd0; g_wb = 0; g_nack = nack_at;
      arb_at = a_at; to_at = t_at; exp_rx_n = 0; exp_tx = 0;
      for (int k = 0; k < 32; k++) tx_buf[k] = 8'(k * 73 + int'(addr) + 17);
      if (len == 0) g_res = 3'd1;
      else begin
         if (!nos) begin
            emit(3'd0, 1'b0, 1'b0);
            if (!g_halt) begin
               if (ten) begin
                  send_wbyte({5'b11110, addr[9:8], rd}, 3'd2);
                  if (!g_halt) send_wbyte(addr[7:0], 3'd2);
               end else begin
                  send_wbyte({addr[6:0], rd}, 3'd2);
               end
            end
         end
         for (int k = 0; k < len; k++) begin
            if (!g_halt) begin
               if (rd) begin
                  logic [7:0] d;
                  d = 8'(k * 151 + int'(addr) * 3 + 9);
                  for (int i = 7; i >= 0; i--) if (!g_halt) emit(3'd3, 1'b0, d[i]);
                  if (!g_halt) emit(3'd2, (k == len - 1), 1'b0);
                  if (!g_halt) begin
                     exp_rx[exp_rx_n] = d;
                     exp_rx_n++;
                  end
               end else begin
                  exp_tx++;
                  send_wbyte(tx_buf[k], 3'd3);
               end
            end
         end
         if (!g_halt && !nop) emit(3'd1, 1'b0, 1'b0);
         if (g_halt) begin
            eop[ne] = 3'd4; ebit[ne] = 1'b0; resp[ne] = 1'b0; ne++;
         end
      end
      // ---- drive ----
      @(negedge clk);
      log_n = 0; rx_n = 0; tx_idx = 0; tx_gap = 1; tx_taken = 1'b0;
      tx_valid = 1'b0; tx_n = rd ? 0 : len; tx_en = 1'b1;
      start = 1'b1; req_addr = addr; req_ten_bit = ten; req_read = rd;
      req_len = LEN_W'(len); req_no_start = nos; req_no_stop = nop;
      @(negedge clk);
      start = 1'b0;
      wait_n = 0;
      while (!done && wait_n < 5000) begin
         @(negedge clk);
         wait_n++;
      end
      chk(done, "R13", "done pulse seen", int'(done), 1);
      chk(result == g_res, tag, "result code", int'(result), int'(g_res));
      if (len == 0) begin
         chk(wait_n == 0 && log_n == 0, "R9", "zero length latency/requests",
             wait_n * 1000 + log_n, 0);
      end
      bad_at = -1;
      for (int i = 0; i < ne && i < log_n; i++) begin
         if (bad_at < 0) begin
            if (log_op[i] != eop[i] || (eop[i] == 3'd2 && log_bit[i] != ebit[i]))
               bad_at = i;
         end
      end
      if (bad_at >= 0)
         chk(1'b0, tag, $sformatf("op/bit at index %0d", bad_at),
             int'(log_op[bad_at]) * 2 + int'(log_bit[bad_at]),
             int'(eop[bad_at]) * 2 + int'(ebit[bad_at]));
      else
         chk(log_n == ne, tag, "operation count", log_n, ne);
      if (rd && len > 0) begin
         bad_at = -1;
         for (int i = 0; i < exp_rx_n && i < rx_n; i++)
            if (bad_at < 0 && rx_got[i] != exp_rx[i]) bad_at = i;
         if (bad_at >= 0)
            chk(1'b0, "R8", $sformatf("rx byte %0d", bad_at),
                int'(rx_got[bad_at]), int'(exp_rx[bad_at]));
         else
            chk(rx_n == exp_rx_n, "R12", "rx byte count", rx_n, exp_rx_n);
      end else if (len > 0) begin
         chk(tx_idx == exp_tx, "R12", "tx bytes consumed", tx_idx, exp_tx);
      end
      @(negedge clk);
      tx_en = 1'b0; tx_valid = 1'b0; tx_taken = 1'b0;
      chk(!busy && !be_req, "R13", "idle after done", int'(busy) + int'(be_req), 0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; req_addr = '0; req_ten_bit = 1'b0;
      req_read = 1'b0; req_len = '0; req_no_start = 1'b0; req_no_stop = 1'b0;
      tx_valid = 1'b0; tx_data = '0; tx_en = 1'b0; tx_n = 0; tx_idx = 0;
      tx_gap = 0; tx_taken = 1'b0; rx_ready = 1'b1; rx_n = 0; log_n = 0;
      arb_at = -1; to_at = -1;
      for (int i = 0; i < LOGN; i++) resp[i] = 1'b0;
      repeat (4) @(negedge clk);
      // reset state (R13)
      chk(!busy && !done && !be_req && !tx_ready && !rx_valid && result == 3'd0,
          "R13", "reset state",
          int'(busy) + int'(done) + int'(be_req) + int'(tx_ready) + int'(rx_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 / R5: 7-bit writes over addresses and lengths
      for (int a = 0; a < 4; a++)
         for (int l = 1; l <= 3; l++)
            run("R1,R5", 10'(a * 42 + 1), 1'b0, 1'b0, 1'b0, 1'b0, l, -1, -1, -1);
      run("R1", 10'h07F, 1'b0, 1'b0, 1'b0, 1'b0, 2, -1, -1, -1);
      // R8: 7-bit reads
      for (int a = 0; a < 3; a++)
         for (int l = 1; l <= 4; l++)
            run("R8", 10'(a * 37 + 5), 1'b0, 1'b1, 1'b0, 1'b0, l, -1, -1, -1);
      // R2: 10-bit addresses, all upper-bit values
      for (int hi = 0; hi < 4; hi++)
         for (int lo = 0; lo < 3; lo++)
            for (int d = 0; d < 2; d++)
               run("R2", 10'(hi * 256 + lo * 85), 1'b1, d[0], 1'b0, 1'b0, 2, -1, -1, -1);
      // R3 / R4: flag combinations
      for (int f = 0; f < 4; f++)
         for (int d = 0; d < 2; d++)
            run("R3,R4", 10'h3C, 1'b0, d[0], f[0], f[1], 2, -1, -1, -1);
      run("R4", 10'h155, 1'b1, 1'b0, 1'b0, 1'b1, 1, -1, -1, -1);
      // R9: zero length under every flag mix
      for (int f = 0; f < 8; f++)
         run("R9", 10'h12, 1'b0, f[0], f[1], f[2], 0, -1, -1, -1);
      // R6 / R7: NACK position sweep
      run("R6", 10'h21, 1'b0, 1'b0, 1'b0, 1'b0, 3, 0, -1, -1);
      run("R6", 10'h21, 1'b0, 1'b1, 1'b0, 1'b0, 2, 0, -1, -1);
      run("R6", 10'h2A5, 1'b1, 1'b0, 1'b0, 1'b0, 2, 0, -1, -1);
      run("R6", 10'h2A5, 1'b1, 1'b1, 1'b0, 1'b0, 2, 1, -1, -1);
      for (int p = 1; p <= 3; p++)
         run("R7", 10'h21, 1'b0, 1'b0, 1'b0, 1'b0, 3, p, -1, -1);
      run("R7", 10'h21, 1'b0, 1'b0, 1'b1, 1'b0, 2, 0, -1, -1);
      // R10: arbitration loss at every operation of a write and a read
      for (int i = 0; i < 29; i++)
         run("R10", 10'h4B, 1'b0, 1'b0, 1'b0, 1'b0, 2, -1, i, -1);
      for (int i = 0; i < 29; i++)
         run("R10", 10'h4B, 1'b0, 1'b1, 1'b0, 1'b0, 2, -1, i, -1);
      // R11: stretch timeout sweep, plus priority against arbitration loss
      for (int i = 0; i < 29; i += 2)
         run("R11", 10'h19, 1'b0, 1'b0, 1'b0, 1'b0, 2, -1, -1, i);
      for (int i = 0; i < 29; i += 4)
         run("R11", 10'h19, 1'b0, 1'b1, 1'b0, 1'b0, 2, -1, -1, i);
      for (int i = 0; i < 29; i += 7)
         run("R10", 10'h19, 1'b0, 1'b0, 1'b0, 1'b0, 2, -1, i, i);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule